// File: doc/BRIEF.md
# TDM Transmit Time-Slot Mapper

This block takes a stream of bytes and sends them serially onto one TDM transmit link. Each frame is split into 8-bit time slots. A 32-bit slot-enable mask chooses which slots carry traffic. During a slot the mask leaves unused, the output enable is low, so the pin floats. Two frame layouts are offered. The first is a 256-bit layout of 32 slots. The second is a 193-bit layout that starts with one framing bit and then has 24 slots. Enabling any subset of slots in the mask gives fractional and n×64 channel rates.

The block runs on a fast system clock. It samples the slower link clock through a synchronizer and advances by one bit time on the chosen edge of that clock. The frame start comes from one of two places: an internal bit counter, which drives a frame pulse out, or an external frame pulse that realigns the counter. The polarity of both pulses can be set. Bytes arrive over a valid/ready handshake, one byte at the first bit of every enabled slot. When no byte is ready, the block sends an idle byte of zero and flags the underrun.

Top module: `tdm_tx_slot_mapper`

## Requirements
- R1: In an enabled slot, tx_oe is 1 for all 8 bit times. tx_data carries one input byte, most significant bit first. The byte is taken by a handshake (in_valid and in_ready both high) on the slot's first bit time.
- R2: In a slot whose mask bit is 0, tx_oe and tx_data are both 0 for all 8 bit times, and no byte is taken.
- R3: With cfg_mode_t1=1 the frame is 193 bit times long. Bit 0 is the framing bit and always has tx_oe=0. Slot k covers bits 1+8k to 8+8k for k = 0 to 23. Mask bits 31:24 have no effect.
- R4: With cfg_mode_t1=0 the frame is 256 bit times long, with no framing bit. Slot k covers bits 8k to 8k+7, and mask bit k (cfg_mask_hi holds bits 31:16, cfg_mask_lo holds bits 15:0) enables slot k.
- R5: If in_valid is low on the first bit of an enabled slot, that slot sends 0x00 and underrun is high for exactly one system clock.
- R6: The mask and mode inputs are sampled only on bit 0 of a frame. Changes made in mid-frame first apply in the next frame.
- R7: With cfg_ext_sync=0, fp_out is at its active level (high when cfg_fp_high=1, low when it is 0) for exactly bit 0 of each frame and inactive for every other bit. With cfg_ext_sync=1, fp_out stays inactive.
- R8: With cfg_ext_sync=1, an active level on fp_in, sampled at an active link-clock edge, makes that bit time bit 0 of a new frame, wherever the counter was.
- R9: Outputs change only after the active link-clock edge, which is the rising edge when cfg_edge_fall=0 and the falling edge when it is 1. The other edge leaves them unchanged.
- R10: After reset, tx_oe, tx_data, underrun and in_ready are 0, fp_out is inactive, and the first active edge is bit 0 of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| link_clk | input | 1 | TDM link bit clock, sampled by clk |
| cfg_mode_t1 | input | 1 | 1: 193-bit framed layout, 0: 256-bit layout |
| cfg_mask_lo | input | 16 | Slot enables for slots 15..0 |
| cfg_mask_hi | input | 16 | Slot enables for slots 31..16 |
| cfg_edge_fall | input | 1 | 1: falling link edge is active, 0: rising |
| cfg_ext_sync | input | 1 | 1: frame alignment from fp_in, 0: internal |
| cfg_fp_high | input | 1 | Frame pulse active level (1 high, 0 low) |
| fp_in | input | 1 | External frame pulse |
| fp_out | output | 1 | Generated frame pulse |
| in_valid | input | 1 | Input byte available |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Byte taken this cycle |
| tx_data | output | 1 | Serial transmit bit |
| tx_oe | output | 1 | Transmit drive enable; 0 means the pin floats |
| underrun | output | 1 | One-cycle pulse: idle byte substituted |

## Verification
If the bit position counter holds a wrong value, the error shows at once. The drive-enable pattern moves off the mask by whole bit times, and the frame pulse no longer repeats every 193 or 256 bits, so the next frame boundary (at most 256 link bits away) exposes it. A bad shadow copy of the mask or mode shows up in the first slot that differs from the frame's configuration. A bad shift register shows up within 8 bits, because the bits of a slot come out in the wrong order. Consuming too many or too few bytes shifts every later byte, so every enabled slot after the error is wrong.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  typedef enum logic {
    FRM_E1 = 1'b0,
    FRM_T1 = 1'b1
  } frame_mode_e;
endpackage

// File: rtl/tdm_link_edge.sv
module tdm_link_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic link_clk,
  input  logic fp_in,
  input  logic edge_fall,
  output logic tick,
  output logic fp_level
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] clk_sr;
  logic [TOP:0] fp_sr;
  logic         clk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sr   <= '0;
      fp_sr    <= '0;
      clk_prev <= 1'b0;
    end else begin
      clk_sr   <= {clk_sr[TOP-1:0], link_clk};
      fp_sr    <= {fp_sr[TOP-1:0], fp_in};
      clk_prev <= clk_sr[TOP];
    end
  end

  always_comb begin
    if (edge_fall) tick = clk_prev & ~clk_sr[TOP];
    else           tick = ~clk_prev & clk_sr[TOP];
  end

  assign fp_level = fp_sr[TOP];

  // R9
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/tdm_frame_ctr.sv
module tdm_frame_ctr
  import tdm_tx_pkg::*;
#(
  parameter int SLOTS     = 32,
  parameter int SLOT_BITS = 8,
  parameter int T1_SLOTS  = 24
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tick,
  input  logic                         ext_sync,
  input  logic                         fp_hit,
  input  frame_mode_e                  mode_in,
  input  logic [SLOTS-1:0]             mask_in,
  output logic                         frame_start,
  output logic                         slot_on,
  output logic [$clog2(SLOT_BITS)-1:0] bit_idx
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int BIT_W  = $clog2(SLOT_BITS);
  localparam int POS_W  = SLOT_W + BIT_W;
  localparam int E1_LEN = SLOTS * SLOT_BITS;
  localparam int T1_LEN = T1_SLOTS * SLOT_BITS + 1;
  localparam logic [POS_W-1:0] E1_LAST = POS_W'(E1_LEN - 1);
  localparam logic [POS_W-1:0] T1_LAST = POS_W'(T1_LEN - 1);

  logic [POS_W-1:0]  pos_q;
  frame_mode_e       mode_q;
  logic [SLOTS-1:0]  mask_q;

  logic [POS_W-1:0]  cur_pos;
  logic [POS_W-1:0]  rel;
  logic [SLOT_W-1:0] slot_idx;
  frame_mode_e       eff_mode;
  logic [SLOTS-1:0]  eff_mask;
  logic              fbit;
  logic              last_bit;

  always_comb begin
    cur_pos     = (ext_sync && fp_hit) ? '0 : pos_q;
    frame_start = (cur_pos == '0);
    eff_mode    = frame_start ? mode_in : mode_q;
    eff_mask    = frame_start ? mask_in : mask_q;
    fbit        = (eff_mode == FRM_T1) && frame_start;
    rel         = (eff_mode == FRM_T1) ? cur_pos - 1'b1 : cur_pos;
    slot_idx    = rel[POS_W-1:BIT_W];
    bit_idx     = rel[BIT_W-1:0];
    slot_on     = !fbit && eff_mask[slot_idx] &&
                  ((eff_mode == FRM_E1) || (int'(slot_idx) < T1_SLOTS));
    last_bit    = (eff_mode == FRM_T1) ? (cur_pos == T1_LAST)
                                       : (cur_pos == E1_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      mode_q <= FRM_E1;
      mask_q <= '0;
    end else if (tick) begin
      pos_q <= last_bit ? '0 : cur_pos + 1'b1;
      if (frame_start) begin
        mode_q <= mode_in;
        mask_q <= mask_in;
      end
    end
  end

  // R3
  t1_len_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == FRM_T1) |-> (pos_q <= T1_LAST));

  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(tick && frame_start) |=> $stable(mask_q) && $stable(mode_q));
endmodule

// File: rtl/tdm_slot_serializer.sv
module tdm_slot_serializer #(
  parameter int SLOT_BITS = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tick,
  input  logic                         slot_on,
  input  logic [$clog2(SLOT_BITS)-1:0] bit_idx,
  input  logic                         frame_start,
  input  logic                         gen_fp,
  input  logic                         in_valid,
  input  logic [SLOT_BITS-1:0]         in_data,
  output logic                         in_ready,
  output logic                         tx_data,
  output logic                         tx_oe,
  output logic                         underrun,
  output logic                         fp_act
);
  localparam int MSB = SLOT_BITS - 1;

  logic [MSB:0] shreg;
  logic [MSB:0] byte_now;
  logic         load;

  assign load     = tick && slot_on && (bit_idx == '0);
  assign in_ready = load;
  assign byte_now = in_valid ? in_data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      tx_data  <= 1'b0;
      tx_oe    <= 1'b0;
      underrun <= 1'b0;
      fp_act   <= 1'b0;
    end else begin
      underrun <= load && !in_valid;
      if (tick) begin
        fp_act <= gen_fp && frame_start;
        if (load) begin
          tx_data <= byte_now[MSB];
          shreg   <= {byte_now[MSB-1:0], 1'b0};
          tx_oe   <= 1'b1;
        end else if (slot_on) begin
          tx_data <= shreg[MSB];
          shreg   <= {shreg[MSB-1:0], 1'b0};
          tx_oe   <= 1'b1;
        end else begin
          tx_data <= 1'b0;
          tx_oe   <= 1'b0;
        end
      end
    end
  end

  // R5
  underrun_idle_chk: assert property (@(posedge clk) disable iff (rst)
    underrun |-> (tx_oe && !tx_data));

  // R2
  oe_float_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_oe |-> !tx_data);
endmodule

// File: rtl/tdm_tx_slot_mapper.sv
module tdm_tx_slot_mapper
  import tdm_tx_pkg::*;
#(
  parameter int SLOTS       = 32,
  parameter int SLOT_BITS   = 8,
  parameter int T1_SLOTS    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   link_clk,
  input  logic                   cfg_mode_t1,
  input  logic [SLOTS/2-1:0]     cfg_mask_lo,
  input  logic [SLOTS/2-1:0]     cfg_mask_hi,
  input  logic                   cfg_edge_fall,
  input  logic                   cfg_ext_sync,
  input  logic                   cfg_fp_high,
  input  logic                   fp_in,
  output logic                   fp_out,
  input  logic                   in_valid,
  input  logic [SLOT_BITS-1:0]   in_data,
  output logic                   in_ready,
  output logic                   tx_data,
  output logic                   tx_oe,
  output logic                   underrun
);
  localparam int BIT_W = $clog2(SLOT_BITS);

  logic             tick;
  logic             fp_level;
  logic             fp_hit;
  logic             frame_start;
  logic             slot_on;
  logic [BIT_W-1:0] bit_idx;
  logic             fp_act;
  frame_mode_e      mode_sel;

  assign mode_sel = cfg_mode_t1 ? FRM_T1 : FRM_E1;
  assign fp_hit   = cfg_fp_high ? fp_level : ~fp_level;
  assign fp_out   = cfg_fp_high ? fp_act : ~fp_act;

  tdm_link_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
    .clk       (clk),
    .rst       (rst),
    .link_clk  (link_clk),
    .fp_in     (fp_in),
    .edge_fall (cfg_edge_fall),
    .tick      (tick),
    .fp_level  (fp_level)
  );

  tdm_frame_ctr #(
    .SLOTS     (SLOTS),
    .SLOT_BITS (SLOT_BITS),
    .T1_SLOTS  (T1_SLOTS)
  ) ctr_i (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .ext_sync    (cfg_ext_sync),
    .fp_hit      (fp_hit),
    .mode_in     (mode_sel),
    .mask_in     ({cfg_mask_hi, cfg_mask_lo}),
    .frame_start (frame_start),
    .slot_on     (slot_on),
    .bit_idx     (bit_idx)
  );

  tdm_slot_serializer #(.SLOT_BITS(SLOT_BITS)) ser_i (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .slot_on     (slot_on),
    .bit_idx     (bit_idx),
    .frame_start (frame_start),
    .gen_fp      (!cfg_ext_sync),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_ready    (in_ready),
    .tx_data     (tx_data),
    .tx_oe       (tx_oe),
    .underrun    (underrun),
    .fp_act      (fp_act)
  );

  // R1
  ready_on_slot_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> tx_oe);
endmodule

// File: tb/tdm_tx_slot_mapper_tb_top.sv
module tdm_tx_slot_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        link_clk = 1'b0;
  logic        cfg_mode_t1 = 1'b0;
  logic [15:0] cfg_mask_lo = '0;
  logic [15:0] cfg_mask_hi = '0;
  logic        cfg_edge_fall = 1'b0;
  logic        cfg_ext_sync = 1'b0;
  logic        cfg_fp_high = 1'b1;
  logic        fp_in = 1'b0;
  logic        fp_out;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic        tx_data;
  logic        tx_oe;
  logic        underrun;

  always #2.5 clk = ~clk;

  tdm_tx_slot_mapper dut_i (
    .clk(clk), .rst(rst), .link_clk(link_clk), .cfg_mode_t1(cfg_mode_t1),
    .cfg_mask_lo(cfg_mask_lo), .cfg_mask_hi(cfg_mask_hi),
    .cfg_edge_fall(cfg_edge_fall), .cfg_ext_sync(cfg_ext_sync),
    .cfg_fp_high(cfg_fp_high), .fp_in(fp_in), .fp_out(fp_out),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .tx_data(tx_data), .tx_oe(tx_oe), .underrun(underrun)
  );

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] src_q[$];
  logic [7:0] mdl_q[$];
  logic [2:0] exp_q[$];
  logic [2:0] held = 3'b000;
  bit pend = 1'b0;
  int under_cnt = 0;
  int exp_under = 0;
  int oe_cnt = 0;
  int fp_cnt = 0;

  int          mpos = 0;
  logic        m_t1 = 1'b0;
  logic [31:0] m_mask = '0;
  logic [7:0]  m_byte = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic push_byte(input logic [7:0] b);
    src_q.push_back(b);
    mdl_q.push_back(b);
  endtask

  function automatic logic [2:0] as_port(input logic [2:0] item);
    return {cfg_fp_high ? item[2] : ~item[2], item[1], item[0]};
  endfunction

  // Feeder: handshake seen at one negedge is retired at the next one.
  always @(negedge clk) begin
    bit hs_now;
    hs_now = in_valid && in_ready;
    if (pend) void'(src_q.pop_front());
    pend = hs_now;
    in_valid = (src_q.size() > 0);
    in_data  = (src_q.size() > 0) ? src_q[0] : 8'h00;
  end

  always @(negedge clk) if (underrun) under_cnt++;

  // Driver side of the scoreboard: expected item for one bit time.
  task automatic mdl_step(input bit fp_hit);
    logic oe, d;
    int rel, slot, b, len;
    if (cfg_ext_sync && fp_hit) mpos = 0;
    if (mpos == 0) begin
      m_t1   = cfg_mode_t1;
      m_mask = {cfg_mask_hi, cfg_mask_lo};
    end
    len = m_t1 ? 193 : 256;
    oe = 1'b0;
    d  = 1'b0;
    if (!(m_t1 && mpos == 0)) begin
      rel  = m_t1 ? mpos - 1 : mpos;
      slot = rel / 8;
      b    = rel % 8;
      if (m_mask[slot]) begin
        if (b == 0) begin
          if (mdl_q.size() > 0) m_byte = mdl_q.pop_front();
          else begin
            m_byte = 8'h00;
            exp_under++;
          end
        end
        oe = 1'b1;
        d  = m_byte[7-b];
      end
    end
    exp_q.push_back({(!cfg_ext_sync && mpos == 0), oe, d});
    mpos = (mpos + 1 == len) ? 0 : mpos + 1;
  endtask

  // One link bit time; the monitor pops after the active edge.
  task automatic step(input string req, input bit fp_hit);
    logic [2:0] got;
    @(negedge clk);
    link_clk = cfg_edge_fall;
    repeat (4) @(negedge clk);
    chk("R9", {fp_out, tx_oe, tx_data}, as_port(held));
    link_clk = ~cfg_edge_fall;
    fp_in = fp_hit ? cfg_fp_high : ~cfg_fp_high;
    mdl_step(fp_hit);
    repeat (4) @(negedge clk);
    got = {fp_out, tx_oe, tx_data};
    if (exp_q.size() == 0) chk(req, 32'hdead, 32'h0);
    else begin
      held = exp_q.pop_front();
      chk(req, got, as_port(held));
    end
    if (tx_oe) oe_cnt++;
    if (fp_out == cfg_fp_high) fp_cnt++;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10", {tx_oe, tx_data, underrun, in_ready}, 4'b0000);
    chk("R10", fp_out, 1'b0);

    // Phase A: 256-bit layout, slots 0, 2, 31
    cfg_mask_hi = 16'h8000; cfg_mask_lo = 16'h0005;
    push_byte(8'hA5); push_byte(8'h3C); push_byte(8'hF0);
    oe_cnt = 0; fp_cnt = 0;
    for (int i = 0; i < 256; i++) step("R4", 1'b0);
    chk("R1", src_q.size(), 0);
    chk("R2", oe_cnt, 24);
    chk("R7", fp_cnt, 1);

    // Phase B: 193-bit layout, slots 0 and 23; upper mask bits set
    cfg_mode_t1 = 1'b1; cfg_mask_hi = 16'hFF80; cfg_mask_lo = 16'h0001;
    push_byte(8'h81); push_byte(8'h7E);
    for (int i = 0; i < 193; i++) step("R3", 1'b0);
    chk("R3", src_q.size(), 0);
    cfg_mask_hi = 16'hFF00; cfg_mask_lo = 16'h0000;
    push_byte(8'h44);
    oe_cnt = 0;
    for (int i = 0; i < 193; i++) step("R3", 1'b0);
    chk("R3", oe_cnt, 0);
    chk("R3", src_q.size(), 1);

    // Phase C: mid-frame change applies at next boundary
    cfg_mode_t1 = 1'b0; cfg_mask_hi = 16'h0000; cfg_mask_lo = 16'h0002;
    for (int i = 0; i < 100; i++) step("R6", 1'b0);
    cfg_mode_t1 = 1'b1; cfg_mask_hi = 16'hC000; cfg_mask_lo = 16'h0010;
    push_byte(8'h5A);
    for (int i = 0; i < 156 + 193; i++) step("R6", 1'b0);
    chk("R6", src_q.size(), 0);

    // Phase D: underrun on the second enabled slot
    cfg_mode_t1 = 1'b0; cfg_mask_hi = 16'h0000; cfg_mask_lo = 16'h0003;
    push_byte(8'hC3);
    for (int i = 0; i < 256; i++) step("R5", 1'b0);
    chk("R5", under_cnt, exp_under);
    chk("R5", under_cnt, 1);

    // Phase E: external alignment, active-low pulse
    cfg_ext_sync = 1'b1; cfg_fp_high = 1'b0; cfg_mask_lo = 16'h0001;
    push_byte(8'h11); push_byte(8'h22);
    for (int i = 0; i < 40; i++) step("R8", 1'b0);
    step("R8", 1'b1);
    for (int i = 0; i < 20; i++) step("R8", 1'b0);
    chk("R8", src_q.size(), 0);

    // Phase F: falling link edge, internal pulse again
    cfg_ext_sync = 1'b0; cfg_fp_high = 1'b1; cfg_edge_fall = 1'b1;
    push_byte(8'h99);
    for (int i = 0; i < 243; i++) step("R9", 1'b0);
    chk("R9", src_q.size(), 0);
    chk("R5", under_cnt, exp_under);
    chk("R1", exp_q.size(), 0);

    done = 1'b1;
    finish_run();
  end
endmodule